// File: doc/BRIEF.md
# Page Entry Access Permission Checker

This block judges a single memory access against a leaf translation entry that has already been fetched. It is given the 64-bit entry, the address the entry was read from, the kind of access (read, write or instruction fetch), whether the processor runs in user (problem) state, and a 3-bit permission mask that software keeps for supervisor accesses. From these it works out the read/write/execute rights that the access receives and reports a fault if the requested right is absent. When there is no fault, it also forms the updated entry with the referenced and changed flags set.

A read or fetch never receives write permission, even when the entry allows writes. A later store to the same page therefore comes back through this block, which sets the changed flag at that point. The updated entry goes out as a write-back request only when its value actually differs from the entry that came in. A request is accepted on any cycle that has `req_valid` high. The response, the permission mask and any write-back appear together one clock later.

Entry fields (bit 0 is the least significant bit): bits [2:0] hold the access authority (bit 0 read, bit 1 write, bit 2 execute). Bit 3 is the privileged flag. Bits [5:4] hold the memory attribute, where 2'b10 means non-idempotent I/O. Bit 7 is the changed flag and bit 8 is the referenced flag. Permission masks use the same bit order as the authority field: bit 0 read, bit 1 write, bit 2 execute. Cause bit 0 marks a guarded no-execute fault and cause bit 1 marks a protection fault.

Top module: `pte_perm_checker`

## Requirements
- R1: An instruction fetch (`req_kind` 2) of an entry whose attribute bits [5:4] are 2'b10 faults with cause 2'b01 (guarded no-execute) and permission mask 3'b000. This holds whatever the access authority allows. The attribute field has no effect on reads or writes.
- R2: If the entry's privileged bit 3 is set and `req_user` is 1, the granted rights are 3'b000.
- R3: If exactly one of `req_user` and privileged bit 3 is set, the granted rights equal the authority bits [2:0]. `req_amr_perm` is ignored in that case.
- R4: If `req_user` is 0 and privileged bit 3 is clear, the granted rights are the authority bits [2:0] ANDed with `req_amr_perm`.
- R5: When the right needed by the access is missing from the granted rights, the response faults with cause 2'b10 (protection). Read needs bit 0, write needs bit 1 and fetch needs bit 2. Otherwise the response has no fault and cause 2'b00.
- R6: The updated entry is the input entry with referenced bit 8 set. Changed bit 7 is also set on a write (`req_kind` 1) and is kept as it was on any other access.
- R7: For any access other than a write, bit 1 (write) of `resp_perm` is 0. For a write, `resp_perm` equals the granted rights.
- R8: A write-back is issued only if the updated entry differs from the input entry.
- R9: `wb_valid` is a one-cycle pulse in the cycle after the request, carrying the updated entry and `req_pte_addr`. It never comes with a fault.
- R10: Access kind code 3 is treated exactly as a read.
- R11: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_pte | input | 64 | Leaf translation entry |
| req_pte_addr | input | 64 | Address the entry was read from |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| req_user | input | 1 | Processor is in user (problem) state |
| req_amr_perm | input | 3 | Supervisor permission mask (bit 0 r, 1 w, 2 x) |
| resp_valid | output | 1 | Response present |
| resp_fault | output | 1 | Access denied |
| resp_cause | output | 2 | Bit 0 guarded no-execute, bit 1 protection |
| resp_perm | output | 3 | Returned rights (bit 0 r, 1 w, 2 x) |
| wb_valid | output | 1 | Write-back request pulse |
| wb_pte | output | 64 | Updated entry value |
| wb_addr | output | 64 | Address for the write-back |

## Verification
The bench aims at the fetch of a non-idempotent I/O page whose authority grants execute. A design that checks authority first would wrongly let that fetch through. It also sends a privileged page in user state with all authority bits set, which a design that ORs instead of choosing would grant. It covers reads of pages whose referenced flag is already set, and writes to pages whose two flags are both already set. A block that always writes back, or that sets the changed flag on reads, would issue a needless or wrong write-back there. Random entries, masks and modes are compared against a bench model, including access code 3 and the check that write permission is dropped on reads.

// File: rtl/pte_perm_pkg.sv
package pte_perm_pkg;

    localparam int EAA_LSB      = 0;
    localparam int PRIV_BIT     = 3;
    localparam int ATTR_LSB     = 4;
    localparam int ATTR_W       = 2;
    localparam int CHG_BIT      = 7;
    localparam int REF_BIT      = 8;
    localparam logic [ATTR_W-1:0] ATTR_NONIDEM_IO = 2'b10;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALIAS = 2'd3
    } access_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic prot;
        logic guard;
    } cause_t;

    localparam perm_t PERM_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};

    function automatic access_e fold_kind(input access_e k);
        return (k == ACC_ALIAS) ? ACC_READ : k;
    endfunction

    function automatic perm_t right_needed(input access_e k);
        perm_t p;
        p = PERM_NONE;
        case (k)
            ACC_WRITE: p.w = 1'b1;
            ACC_FETCH: p.x = 1'b1;
            default:   p.r = 1'b1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pte_grant.sv
module pte_grant
    import pte_perm_pkg::*;
(
    input  perm_t authority,
    input  logic  priv_page,
    input  logic  user_mode,
    input  perm_t amr_mask,
    output perm_t granted
);
    always_comb begin
        if (priv_page && user_mode) begin
            granted = PERM_NONE;
        end else if (priv_page || user_mode) begin
            granted = authority;
        end else begin
            granted = authority & amr_mask;
        end
    end
endmodule

// File: rtl/pte_judge.sv
module pte_judge
    import pte_perm_pkg::*;
#(
    parameter int ATTR_BITS = ATTR_W
) (
    input  access_e              kind,
    input  logic [ATTR_BITS-1:0] attr,
    input  perm_t                granted,
    output logic                 fault,
    output cause_t               cause,
    output perm_t                perm_out
);
    perm_t need;
    logic  guarded_fetch;

    always_comb begin
        need          = right_needed(kind);
        guarded_fetch = (kind == ACC_FETCH) && (attr == ATTR_NONIDEM_IO);
        cause         = '0;
        perm_out      = granted;
        if (kind != ACC_WRITE) begin
            perm_out.w = 1'b0;
        end
        if (guarded_fetch) begin
            cause.guard = 1'b1;
            perm_out    = PERM_NONE;
        end else if ((need & ~granted) != PERM_NONE) begin
            cause.prot = 1'b1;
        end
        fault = cause.guard | cause.prot;
    end
endmodule

// File: rtl/pte_rc_update.sv
module pte_rc_update
    import pte_perm_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  access_e          kind,
    input  logic [PTE_W-1:0] old_pte,
    output logic [PTE_W-1:0] new_pte,
    output logic             differs
);
    always_comb begin
        new_pte          = old_pte;
        new_pte[REF_BIT] = 1'b1;
        if (kind == ACC_WRITE) begin
            new_pte[CHG_BIT] = 1'b1;
        end
        differs = (new_pte != old_pte);
    end
endmodule

// File: rtl/pte_perm_checker.sv
module pte_perm_checker
    import pte_perm_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PTE_W-1:0]  req_pte,
    input  logic [ADDR_W-1:0] req_pte_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic [2:0]        req_amr_perm,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [1:0]        resp_cause,
    output logic [2:0]        resp_perm,
    output logic              wb_valid,
    output logic [PTE_W-1:0]  wb_pte,
    output logic [ADDR_W-1:0] wb_addr
);
    access_e            kind_n;
    perm_t              authority;
    perm_t              granted;
    perm_t              perm_c;
    cause_t             cause_c;
    logic               fault_c;
    logic [PTE_W-1:0]   new_pte_c;
    logic               differs_c;

    assign kind_n    = fold_kind(access_e'(req_kind));
    assign authority = perm_t'(req_pte[EAA_LSB +: 3]);

    pte_grant u_grant (
        .authority (authority),
        .priv_page (req_pte[PRIV_BIT]),
        .user_mode (req_user),
        .amr_mask  (perm_t'(req_amr_perm)),
        .granted   (granted)
    );

    pte_judge #(.ATTR_BITS(ATTR_W)) u_judge (
        .kind     (kind_n),
        .attr     (req_pte[ATTR_LSB +: ATTR_W]),
        .granted  (granted),
        .fault    (fault_c),
        .cause    (cause_c),
        .perm_out (perm_c)
    );

    pte_rc_update #(.PTE_W(PTE_W)) u_rc (
        .kind    (kind_n),
        .old_pte (req_pte),
        .new_pte (new_pte_c),
        .differs (differs_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_cause <= '0;
            resp_perm  <= '0;
            wb_valid   <= 1'b0;
            wb_pte     <= '0;
            wb_addr    <= '0;
        end else begin
            resp_valid <= req_valid;
            wb_valid   <= req_valid && !fault_c && differs_c;
            if (req_valid) begin
                resp_fault <= fault_c;
                resp_cause <= cause_c;
                resp_perm  <= perm_c;
                wb_pte     <= new_pte_c;
                wb_addr    <= req_pte_addr;
            end
        end
    end
endmodule

// File: rtl/pte_perm_checker_sva.sv
module pte_perm_checker_sva
    import pte_perm_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [PTE_W-1:0]  req_pte,
    input logic [ADDR_W-1:0] req_pte_addr,
    input logic [1:0]        req_kind,
    input logic              req_user,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [1:0]        resp_cause,
    input logic [2:0]        resp_perm,
    input logic              wb_valid,
    input logic [PTE_W-1:0]  wb_pte,
    input logic [ADDR_W-1:0] wb_addr
);
    a_r1_guarded_fetch: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && $past(req_kind == 2'd2 && req_pte[ATTR_LSB +: ATTR_W] == ATTR_NONIDEM_IO))
        |-> (resp_fault && resp_cause == 2'b01 && resp_perm == 3'b000));

    a_r2_user_on_priv: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && $past(req_user && req_pte[PRIV_BIT])) |-> (resp_perm == 3'b000));

    a_r6_ref_set: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> wb_pte[REF_BIT]);

    a_r6_chg_rule: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_pte[CHG_BIT] == ($past(req_kind) == 2'd1 || $past(req_pte[CHG_BIT]))));

    a_r7_no_write_on_read: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && $past(req_kind) != 2'd1) |-> !resp_perm[1]);

    a_r8_wb_changes_entry: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_pte != $past(req_pte)));

    a_r9_wb_no_fault: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (resp_valid && !resp_fault));

    a_r9_wb_addr: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_addr == $past(req_pte_addr)));

    a_r11_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
endmodule

bind pte_perm_checker pte_perm_checker_sva #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_pte      (req_pte),
    .req_pte_addr (req_pte_addr),
    .req_kind     (req_kind),
    .req_user     (req_user),
    .resp_valid   (resp_valid),
    .resp_fault   (resp_fault),
    .resp_cause   (resp_cause),
    .resp_perm    (resp_perm),
    .wb_valid     (wb_valid),
    .wb_pte       (wb_pte),
    .wb_addr      (wb_addr)
);

// File: tb/tb_pte_perm_checker.sv
module tb_pte_perm_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_pte = '0;
    logic [63:0] req_pte_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [2:0]  req_amr_perm = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic [1:0]  resp_cause;
    logic [2:0]  resp_perm;
    logic        wb_valid;
    logic [63:0] wb_pte;
    logic [63:0] wb_addr;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    pte_perm_checker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pte(req_pte),
        .req_pte_addr(req_pte_addr), .req_kind(req_kind), .req_user(req_user),
        .req_amr_perm(req_amr_perm), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_cause(resp_cause), .resp_perm(resp_perm), .wb_valid(wb_valid),
        .wb_pte(wb_pte), .wb_addr(wb_addr)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench model of the expected response
    typedef struct {
        logic        fault;
        logic [1:0]  cause;
        logic [2:0]  perm;
        logic        wb;
        logic [63:0] npte;
    } exp_t;

    function automatic exp_t model(input logic [63:0] pte, input logic [1:0] kind,
                                   input logic user, input logic [2:0] amr);
        exp_t e;
        logic [1:0] a;
        logic [2:0] gr, need;
        a = (kind == 2'd3) ? 2'd0 : kind;
        e.npte = pte | 64'h100 | ((a == 2'd1) ? 64'h80 : 64'h0);
        if (a == 2'd2 && pte[5:4] == 2'b10) begin
            e.fault = 1'b1; e.cause = 2'b01; e.perm = 3'b000; e.wb = 1'b0;
            return e;
        end
        if (pte[3] && user)      gr = 3'b000;
        else if (pte[3] || user) gr = pte[2:0];
        else                     gr = pte[2:0] & amr;
        need = (a == 2'd0) ? 3'b001 : (a == 2'd1) ? 3'b010 : 3'b100;
        e.perm  = (a != 2'd1) ? (gr & 3'b101) : gr;
        e.fault = ((need & ~gr) != 3'b000);
        e.cause = e.fault ? 2'b10 : 2'b00;
        e.wb    = !e.fault && (e.npte != pte);
        return e;
    endfunction

    task automatic run_req(input string tag, input logic [63:0] pte, input logic [63:0] addr,
                           input logic [1:0] kind, input logic user, input logic [2:0] amr);
        exp_t e;
        e = model(pte, kind, user, amr);
        @(negedge clk);
        req_valid = 1'b1; req_pte = pte; req_pte_addr = addr;
        req_kind = kind; req_user = user; req_amr_perm = amr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R11 resp_valid"}, 64'(resp_valid), 64'd1);
        check({tag, " R5 fault"}, 64'(resp_fault), 64'(e.fault));
        check({tag, " R1/R5 cause"}, 64'(resp_cause), 64'(e.cause));
        check({tag, " R7 perm"}, 64'(resp_perm), 64'(e.perm));
        check({tag, " R8 wb_valid"}, 64'(wb_valid), 64'(e.wb));
        if (e.wb) begin
            check({tag, " R6 wb_pte"}, wb_pte, e.npte);
            check({tag, " R9 wb_addr"}, wb_addr, addr);
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 reset resp_valid", 64'(resp_valid), 0);
        check("R11 reset wb_valid", 64'(wb_valid), 0);
        check("R11 reset wb_pte", wb_pte, 0);
        check("R11 reset perm", 64'(resp_perm), 0);

        // R1: fetch of I/O page with full authority still faults
        run_req("R1 io fetch", 64'h0000_0000_0000_0027, 64'h1000, 2'd2, 1'b0, 3'b111);
        // R1: same attribute, read is unaffected
        run_req("R1 io read", 64'h0000_0000_0000_0027, 64'h1008, 2'd0, 1'b0, 3'b111);
        // R2: privileged page in user state, full authority
        run_req("R2 user priv", 64'h0000_0000_0000_000F, 64'h1010, 2'd0, 1'b1, 3'b111);
        // R3: user non-priv, amr ignored
        run_req("R3 user", 64'h0000_0000_0000_0007, 64'h1018, 2'd1, 1'b1, 3'b000);
        run_req("R3 sup priv", 64'h0000_0000_0000_000C, 64'h1020, 2'd2, 1'b0, 3'b000);
        // R4: supervisor non-priv masked
        run_req("R4 masked write", 64'h0000_0000_0000_0007, 64'h1028, 2'd1, 1'b0, 3'b101);
        run_req("R4 masked read", 64'h0000_0000_0000_0007, 64'h1030, 2'd0, 1'b0, 3'b001);
        // R7: read on writable page drops write
        run_req("R7 read rw", 64'h0000_0000_0000_0003, 64'h1038, 2'd0, 1'b1, 3'b000);
        // R8: read with ref already set -> no write-back
        run_req("R8 ref set read", 64'h0000_0000_0000_0101, 64'h1040, 2'd0, 1'b1, 3'b000);
        // R8: write with both set -> no write-back
        run_req("R8 both set write", 64'h0000_0000_0000_0183, 64'h1048, 2'd1, 1'b1, 3'b000);
        // R6: write with ref set, chg clear -> write-back
        run_req("R6 set chg", 64'hABCD_0000_0000_0103, 64'h1050, 2'd1, 1'b1, 3'b000);
        // R10: kind 3 behaves like read
        run_req("R10 alias", 64'h0000_0000_0000_0003, 64'h1058, 2'd3, 1'b1, 3'b000);
        run_req("R10 alias deny", 64'h0000_0000_0000_0006, 64'h1060, 2'd3, 1'b1, 3'b000);
        // R9: pulse gone the cycle after
        run_req("R9 pulse", 64'h0000_0000_0000_0001, 64'h2000, 2'd0, 1'b1, 3'b000);
        @(negedge clk);
        check("R9 wb pulse ends", 64'(wb_valid), 0);
        check("R11 resp_valid idle", 64'(resp_valid), 0);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] p;
            p = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 0) p[8] = 1'b1;
            if ($urandom_range(0, 2) == 0) p[5:4] = 2'b10;
            run_req("RND", p, {$urandom, $urandom}, 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule